// File: doc/BRIEF.md
# Display Window and Orientation Command Generator

This block sits between a drawing engine and a small TFT panel controller. It turns two kinds of request into command sequences on the controller's 9-bit serial link. A window request names the rectangle that the following pixel data will fill. An orientation request selects one of four panel rotations and the red/blue order. Each serial word is a command/data flag followed by one byte. The pixel stream that follows the memory-write command is produced elsewhere and is not part of this block.

The panel is 176 columns by 220 rows, so every coordinate fits in one byte. The controller expects each coordinate as two bytes, so the block sends a zero high byte before each one. Requests are taken only while `ready` is high. All request inputs are captured on the accepting clock edge. After that the block runs on its own until the last bit has left the serial port.

Top module: `panel_cmd_gen`

## Requirements
- R1: After reset, `ready` is 1, `ser_cs_n` is 1 and `ser_clk` is 0.
- R2: Each word is framed by `ser_cs_n` low and carries exactly 9 bits, sampled by the receiver on the rising edge of `ser_clk`. The flag is sent first (0 = command, 1 = parameter), then the byte MSB first. `ser_dat` changes only while `ser_clk` is low. `ser_clk` is 0 whenever `ser_cs_n` is 1.
- R3: A window request sends 11 words: command 0x2A, parameters 0x00, start column, 0x00, end column; command 0x2B, parameters 0x00, start row, 0x00, end row; command 0x2C with no parameters.
- R4: An orientation request sends command 0x36 followed by one parameter byte.
- R5: The rotation code sets bits 7:5 of that parameter. Code 0 (0°) gives 000. Code 1 (90°) gives 101. Code 2 (180°) gives 110. Code 3 (270°) gives 011. Bits 4 and 2:0 are 0.
- R6: Bit 3 of the orientation parameter equals the BGR select input.
- R7: When both request strobes are high on an accepting edge, the orientation sequence is sent first and the window sequence follows it.
- R8: `ready` goes low on the edge that accepts a request. It returns high only after the last bit of the sequence has been shifted out. Strobes seen while `ready` is low are ignored.
- R9: A start coordinate larger than its end coordinate is sent unchanged.
- R10: Coordinates, rotation code and BGR select are captured when the request is accepted. Later changes to these inputs do not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_req | input | 1 | Window update strobe |
| rot_req | input | 1 | Orientation update strobe |
| col_start | input | 8 | First column of the window |
| col_end | input | 8 | Last column of the window |
| row_start | input | 8 | First row of the window |
| row_end | input | 8 | Last row of the window |
| rot_code | input | 2 | Rotation: 0=0°, 1=90°, 2=180°, 3=270° |
| bgr_sel | input | 1 | Red/blue order select |
| ready | output | 1 | Block idle, a request may be presented |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data |
| ser_cs_n | output | 1 | Serial word frame, active low |

## Verification
The bench decodes the serial line back into 9-bit words. It compares each word against sequences computed from the requirements, for all four rotations with both BGR values, the full-panel window, reversed windows and random windows. Each corner case targets a likely mistake:
- A swapped flag or bit order would turn every word into garbage.
- A wrong rotation table would put the bits for one angle in place of another.
- Reversing the order for simultaneous strobes would send the window first.
- Dropping the pending window would lose 11 words.
- Reading coordinates live instead of latching them would corrupt a window when the inputs change mid-sequence.
- Accepting a strobe while busy would add extra words to the count.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 1;

  localparam logic [BYTE_W-1:0] OP_COL_ADDR  = 8'h2A;
  localparam logic [BYTE_W-1:0] OP_ROW_ADDR  = 8'h2B;
  localparam logic [BYTE_W-1:0] OP_MEM_WRITE = 8'h2C;
  localparam logic [BYTE_W-1:0] OP_ACCESS    = 8'h36;

  localparam int ROT_WORDS = 2;
  localparam int WIN_WORDS = 11;

  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;

  typedef enum logic {
    SEQ_ROT = 1'b0,
    SEQ_WIN = 1'b1
  } seq_e;

  typedef struct packed {
    logic              is_par;
    logic [BYTE_W-1:0] val;
  } cword_t;
endpackage

// File: rtl/rot_encoder.sv
module rot_encoder
  import panel_cmd_pkg::*;
(
  input  logic [1:0]        rot_code,
  input  logic              bgr_sel,
  output logic [BYTE_W-1:0] access_byte
);
  logic [2:0] flip;

  always_comb begin
    unique case (rot_e'(rot_code))
      ROT_0:   flip = 3'b000;
      ROT_90:  flip = 3'b101;
      ROT_180: flip = 3'b110;
      ROT_270: flip = 3'b011;
      default: flip = 3'b000;
    endcase
    access_byte = {flip, 1'b0, bgr_sel, 3'b000};
  end
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import panel_cmd_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_req,
  input  logic               rot_req,
  input  logic [COORD_W-1:0] col_start,
  input  logic [COORD_W-1:0] col_end,
  input  logic [COORD_W-1:0] row_start,
  input  logic [COORD_W-1:0] row_end,
  input  logic [BYTE_W-1:0]  access_in,
  input  logic               ser_idle,
  output logic               w_valid,
  output cword_t             w_word,
  output logic               busy
);
  localparam int IDX_W    = $clog2(WIN_WORDS);
  localparam int WIN_LAST = WIN_WORDS - 1;
  localparam int ROT_LAST = ROT_WORDS - 1;

  logic               busy_q, busy_d;
  logic               pend_q, pend_d;
  seq_e               mode_q, mode_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [COORD_W-1:0] xs_q, xs_d, xe_q, xe_d, ys_q, ys_d, ye_q, ye_d;
  logic [BYTE_W-1:0]  acc_q, acc_d;

  logic accept, advance, last;

  always_comb begin
    accept  = !busy_q && ser_idle && (win_req || rot_req);
    advance = busy_q && ser_idle;
    last    = (mode_q == SEQ_ROT) ? (idx_q == IDX_W'(ROT_LAST))
                                  : (idx_q == IDX_W'(WIN_LAST));
    busy_d = busy_q;
    pend_d = pend_q;
    mode_d = mode_q;
    idx_d  = idx_q;
    xs_d = xs_q; xe_d = xe_q; ys_d = ys_q; ye_d = ye_q;
    acc_d  = acc_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      xs_d = col_start; xe_d = col_end;
      ys_d = row_start; ye_d = row_end;
      acc_d = access_in;
      if (rot_req) begin
        mode_d = SEQ_ROT;
        pend_d = win_req;
      end else begin
        mode_d = SEQ_WIN;
        pend_d = 1'b0;
      end
    end else if (advance) begin
      if (!last) begin
        idx_d = idx_q + 1'b1;
      end else if (pend_q) begin
        mode_d = SEQ_WIN;
        pend_d = 1'b0;
        idx_d  = '0;
      end else begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      mode_q <= SEQ_ROT;
      idx_q  <= '0;
      xs_q <= '0; xe_q <= '0; ys_q <= '0; ye_q <= '0;
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      mode_q <= mode_d;
      idx_q  <= idx_d;
      if (accept) begin
        xs_q <= xs_d; xe_q <= xe_d; ys_q <= ys_d; ye_q <= ye_d;
        acc_q <= acc_d;
      end
    end
  end

  always_comb begin
    w_word = '{is_par: 1'b1, val: '0};
    if (mode_q == SEQ_ROT) begin
      if (idx_q == '0) w_word = '{is_par: 1'b0, val: OP_ACCESS};
      else             w_word = '{is_par: 1'b1, val: acc_q};
    end else begin
      unique case (idx_q)
        IDX_W'(0):  w_word = '{is_par: 1'b0, val: OP_COL_ADDR};
        IDX_W'(2):  w_word.val = BYTE_W'(xs_q);
        IDX_W'(4):  w_word.val = BYTE_W'(xe_q);
        IDX_W'(5):  w_word = '{is_par: 1'b0, val: OP_ROW_ADDR};
        IDX_W'(7):  w_word.val = BYTE_W'(ys_q);
        IDX_W'(9):  w_word.val = BYTE_W'(ye_q);
        IDX_W'(10): w_word = '{is_par: 1'b0, val: OP_MEM_WRITE};
        default:    w_word.val = '0;
      endcase
    end
  end

  assign w_valid = busy_q;
  assign busy    = busy_q;

  a_r7_pending_only_after_rot: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (mode_q == SEQ_ROT && busy_q));
  a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= IDX_W'(WIN_LAST)));
  a_r10_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(xs_q) && $stable(ye_q) && $stable(acc_q)));
endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import panel_cmd_pkg::*;
#(
  parameter int HALF_BIT_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  cword_t word,
  output logic   idle,
  output logic   sclk,
  output logic   sdo,
  output logic   cs_n
);
  localparam int CNT_W = $clog2(HALF_BIT_CYC + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} sst_e;

  sst_e               st_q, st_d;
  logic [WORD_W-1:0]  sh_q, sh_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               half_q, half_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cnt_done;

  always_comb begin
    cnt_done = (cnt_q == CNT_W'(HALF_BIT_CYC - 1));
    st_d = st_q; sh_d = sh_q; bit_d = bit_q; half_d = half_q; cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: begin
        if (load) begin
          st_d = S_SHIFT; sh_d = word; bit_d = '0; half_d = 1'b0; cnt_d = '0;
        end
      end
      S_SHIFT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_done) begin
          cnt_d = '0;
          if (!half_q) begin
            half_d = 1'b1;
          end else begin
            half_d = 1'b0;
            if (bit_q == BIT_W'(WORD_W - 1)) begin
              st_d = S_GAP;
            end else begin
              bit_d = bit_q + 1'b1;
              sh_d  = {sh_q[WORD_W-2:0], 1'b0};
            end
          end
        end
      end
      S_GAP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_done) begin
          cnt_d = '0;
          st_d  = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; sh_q <= '0; bit_q <= '0; half_q <= 1'b0; cnt_q <= '0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; bit_q <= bit_d; half_q <= half_d; cnt_q <= cnt_d;
    end
  end

  assign idle = (st_q == S_IDLE);
  assign sclk = half_q;
  assign sdo  = sh_q[WORD_W-1];
  assign cs_n = (st_q != S_SHIFT);

  a_r2_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r2_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));
  a_r2_frame_starts_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(load));
endmodule

// File: rtl/panel_cmd_gen.sv
module panel_cmd_gen
  import panel_cmd_pkg::*;
#(
  parameter int COORD_W      = 8,
  parameter int HALF_BIT_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_req,
  input  logic               rot_req,
  input  logic [COORD_W-1:0] col_start,
  input  logic [COORD_W-1:0] col_end,
  input  logic [COORD_W-1:0] row_start,
  input  logic [COORD_W-1:0] row_end,
  input  logic [1:0]         rot_code,
  input  logic               bgr_sel,
  output logic               ready,
  output logic               ser_clk,
  output logic               ser_dat,
  output logic               ser_cs_n
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [BYTE_W-1:0] access_in;
  logic              ser_idle, w_valid, busy;
  cword_t            w_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rot_encoder u_enc (
    .rot_code    (rot_code),
    .bgr_sel     (bgr_sel),
    .access_byte (access_in)
  );

  cmd_sequencer #(.COORD_W(COORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .win_req   (win_req),
    .rot_req   (rot_req),
    .col_start (col_start),
    .col_end   (col_end),
    .row_start (row_start),
    .row_end   (row_end),
    .access_in (access_in),
    .ser_idle  (ser_idle),
    .w_valid   (w_valid),
    .w_word    (w_word),
    .busy      (busy)
  );

  word_serializer #(.HALF_BIT_CYC(HALF_BIT_CYC)) u_ser (
    .clk  (clk),
    .rst_n(rst_int_n),
    .load (w_valid),
    .word (w_word),
    .idle (ser_idle),
    .sclk (ser_clk),
    .sdo  (ser_dat),
    .cs_n (ser_cs_n)
  );

  assign ready = !busy && ser_idle && rst_int_n;

  a_r8_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ready && (win_req || rot_req)) |=> !ready);
  a_r8_no_frame_when_ready: assert property (@(posedge clk) disable iff (!rst_int_n)
    ready |-> ser_cs_n);
endmodule

// File: tb/panel_cmd_gen_test.sv
`timescale 1ns/1ps
module panel_cmd_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_req = 1'b0, rot_req = 1'b0;
  logic [7:0] col_start = '0, col_end = '0, row_start = '0, row_end = '0;
  logic [1:0] rot_code = '0;
  logic bgr_sel = 1'b0;
  logic ready, ser_clk, ser_dat, ser_cs_n;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  panel_cmd_gen uut (
    .clk(clk), .rst_n(rst_n), .win_req(win_req), .rot_req(rot_req),
    .col_start(col_start), .col_end(col_end), .row_start(row_start), .row_end(row_end),
    .rot_code(rot_code), .bgr_sel(bgr_sel), .ready(ready),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_cs_n(ser_cs_n)
  );

  logic [8:0] rx [0:255];
  int rx_n = 0;
  int nb = 0;
  logic [8:0] sr = '0;
  always @(posedge ser_clk) begin
    if (!ser_cs_n) begin
      sr = {sr[7:0], ser_dat};
      nb = nb + 1;
      if (nb == 9) begin
        rx[rx_n[7:0]] = sr;
        rx_n = rx_n + 1;
        nb = 0;
      end
    end
  end

  int park_err = 0;
  always @(negedge clk) if (rst_n && ser_cs_n && ser_clk) park_err = park_err + 1;

  logic [8:0] ex [0:15];
  int ex_n;

  function automatic logic [7:0] exp_access(input logic [1:0] r, input logic b);
    logic [7:0] v;
    case (r)
      2'd0: v = 8'h00;
      2'd1: v = 8'hA0;
      2'd2: v = 8'hC0;
      default: v = 8'h60;
    endcase
    return v | (8'(b) << 3);
  endfunction

  task automatic add(input logic f, input logic [7:0] v);
    ex[ex_n] = {f, v};
    ex_n = ex_n + 1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic txn(input string req, input bit dr, input bit dw, input logic [1:0] r,
                     input logic b, input logic [7:0] xs, input logic [7:0] xe,
                     input logic [7:0] ys, input logic [7:0] ye, input bit disturb);
    int base;
    while (!ready) @(negedge clk);
    base = rx_n;
    rot_code = r; bgr_sel = b;
    col_start = xs; col_end = xe; row_start = ys; row_end = ye;
    rot_req = dr; win_req = dw;
    @(negedge clk);
    rot_req = 1'b0; win_req = 1'b0;
    check({req, " R8 ready low after accept"}, 32'(ready), 32'd0);
    if (disturb) begin
      col_start = ~xs; col_end = ~xe; row_start = ~ys; row_end = ~ye;
      rot_code = ~r; bgr_sel = ~b;
      repeat (5) @(negedge clk);
      rot_req = 1'b1; win_req = 1'b1;
      @(negedge clk);
      rot_req = 1'b0; win_req = 1'b0;
    end
    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
    ex_n = 0;
    if (dr) begin
      add(1'b0, 8'h36);
      add(1'b1, exp_access(r, b));
    end
    if (dw) begin
      add(1'b0, 8'h2A); add(1'b1, 8'h00); add(1'b1, xs); add(1'b1, 8'h00); add(1'b1, xe);
      add(1'b0, 8'h2B); add(1'b1, 8'h00); add(1'b1, ys); add(1'b1, 8'h00); add(1'b1, ye);
      add(1'b0, 8'h2C);
    end
    check({req, " word count"}, 32'(rx_n - base), 32'(ex_n));
    for (int i = 0; i < ex_n; i++) begin
      if (i < rx_n - base) check({req, $sformatf(" word %0d", i)}, 32'(rx[(base + i) % 256]), 32'(ex[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a, c, d, e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", 32'(ready), 32'd1);
    check("R1 cs_n after reset", 32'(ser_cs_n), 32'd1);
    check("R1 sclk after reset", 32'(ser_clk), 32'd0);

    for (int r = 0; r < 4; r++) begin
      txn("R4 R5 rotation bgr0", 1'b1, 1'b0, 2'(r), 1'b0, 0, 0, 0, 0, 1'b0);
      txn("R5 R6 rotation bgr1", 1'b1, 1'b0, 2'(r), 1'b1, 0, 0, 0, 0, 1'b0);
    end
    txn("R3 full panel window", 1'b0, 1'b1, 0, 0, 8'd0, 8'd175, 8'd0, 8'd219, 1'b0);
    txn("R3 single pixel", 1'b0, 1'b1, 0, 0, 8'd175, 8'd175, 8'd219, 8'd219, 1'b0);
    txn("R9 reversed window", 1'b0, 1'b1, 0, 0, 8'd150, 8'd20, 8'd200, 8'd3, 1'b0);
    txn("R7 both strobes", 1'b1, 1'b1, 2'd1, 1'b1, 8'd10, 8'd90, 8'd5, 8'd60, 1'b0);
    txn("R10 R8 inputs change while busy", 1'b0, 1'b1, 2'd2, 1'b0, 8'h12, 8'h5A, 8'h21, 8'hA5, 1'b1);
    txn("R10 rotation frozen", 1'b1, 1'b0, 2'd3, 1'b1, 0, 0, 0, 0, 1'b1);

    for (int k = 0; k < 20; k++) begin
      a = 8'($urandom_range(0, 175)); c = 8'($urandom_range(0, 175));
      d = 8'($urandom_range(0, 219)); e = 8'($urandom_range(0, 219));
      txn("R3 R7 random", 1'($urandom_range(0, 1)), 1'b1, 2'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)), a, c, d, e, 1'b0);
    end
    txn("R5 random rotation", 1'b1, 1'b0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
        0, 0, 0, 0, 1'b0);

    check("R2 clock parked while deselected", 32'(park_err), 32'd0);
    check("R2 no partial word", 32'(nb), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule